// File: doc/BRIEF.md
# Line Write Sequencer with Half-Frame Egress

This block sits between an incoming pixel stream and a word-addressed memory. Pixels arrive one per handshake and are grouped into lines of a fixed length and frames of a fixed number of lines. The block numbers each pixel by its line and its position in the line, and turns it into a memory write at the matching address. When memory has accepted the final pixel of a line, the block raises a one-cycle interrupt that carries the index of that line. A downstream processor uses this interrupt to start work on the line.

When half of the frame's lines have been fully stored, a read sequencer starts. It issues read requests in the same ascending address order used for the writes. It never waits for earlier reads to return, and it never runs ahead into a line that is not yet complete. Read responses from memory are registered and leave the block as the egress pixel stream.

A frame-start pulse rewinds the write counters, the completed-line count and the read sequencer. Pixels that arrive after the last line of a frame are accepted and dropped, and they latch an overflow flag.

Top module: `line_wr_seq`

## Requirements
- R1: After reset, wr_valid, rd_valid, out_valid, line_irq and overflow are all 0.
- R2: The k-th pixel of a frame, counting from 0, is written with wr_data equal to its pixel value and wr_addr equal to (k / LINE_PIX) * LINE_PIX + (k mod LINE_PIX). Writes leave the block in arrival order.
- R3: While wr_valid is 1 and wr_ready is 0, wr_addr and wr_data hold steady. Every accepted pixel below the frame limit produces exactly one write.
- R4: line_irq is 1 for exactly one cycle, in the cycle after memory accepts a write whose address has pixel field LINE_PIX-1. line_irq_idx then equals the line field of that address.
- R5: No read request is issued until FRAME_LINES/2 lines of the current frame have completed.
- R6: Read addresses run 0, 1, 2, … in ascending order with no gaps. No read targets a line whose line_irq has not yet been raised.
- R7: The read issuer is non-blocking. It issues a new request in the cycle after the previous one is accepted, without waiting for responses. rd_addr holds while rd_valid is 1 and rd_ready is 0.
- R8: out_valid and out_data repeat rd_rsp_valid and rd_rsp_data one cycle later.
- R9: After a frame_start pulse, the next write goes to address 0, line indices restart at 0, and the read sequencer stops and waits for a new half-frame.
- R10: A pixel offered after FRAME_LINES lines have been written is accepted (in_ready=1) but produces no write. It sets overflow, which stays 1 until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle frame-start pulse; rewinds counters and the read sequencer |
| in_valid | input | 1 | Input pixel valid |
| in_data | input | PIX_W | Input pixel |
| in_ready | output | 1 | Block can take a pixel this cycle |
| wr_valid | output | 1 | Memory write request valid |
| wr_addr | output | log2(LINE_PIX*FRAME_LINES) | Memory write word address |
| wr_data | output | PIX_W | Memory write data |
| wr_ready | input | 1 | Memory accepts the write |
| rd_valid | output | 1 | Memory read request valid |
| rd_addr | output | log2(LINE_PIX*FRAME_LINES) | Memory read word address |
| rd_ready | input | 1 | Memory accepts the read request |
| rd_rsp_valid | input | 1 | Read response valid |
| rd_rsp_data | input | PIX_W | Read response data |
| out_valid | output | 1 | Egress pixel valid |
| out_data | output | PIX_W | Egress pixel |
| line_irq | output | 1 | One-cycle line-complete interrupt |
| line_irq_idx | output | log2(FRAME_LINES) | Index of the completed line |
| overflow | output | 1 | Sticky flag for pixels dropped past the frame end |

## Verification
A corrupted pixel or line counter shows up on the first write after the fault as a wrong wr_addr, since the scoreboard compares every write address against its own count. A line counter that slips also shifts line_irq_idx at the next line boundary. Errors in the completed-line count appear at the read side. Reads that start before half a frame, or that run past the stored lines, are caught at the first read handshake after the fault. Read data that goes wrong is caught on out_data two cycles after the request is accepted.

// File: rtl/lws_pkg.sv
package lws_pkg;

  typedef enum logic [1:0] {
    EG_IDLE = 2'd0,
    EG_RUN  = 2'd1,
    EG_DONE = 2'd2
  } eg_state_t;

endpackage

// File: rtl/lws_ingress.sv
module lws_ingress #(
  parameter int PIX_W       = 24,
  parameter int LINE_PIX    = 512,
  parameter int FRAME_LINES = 1024
) (
  input  logic                                         clk,
  input  logic                                         rst,
  input  logic                                         frame_start,
  input  logic                                         in_valid,
  input  logic [PIX_W-1:0]                             in_data,
  output logic                                         in_ready,
  output logic                                         wr_valid,
  output logic [$clog2(LINE_PIX*FRAME_LINES)-1:0]      wr_addr,
  output logic [PIX_W-1:0]                             wr_data,
  input  logic                                         wr_ready,
  output logic                                         overflow
);
  localparam int PIX_CW = $clog2(LINE_PIX);
  localparam int LIDX_W = $clog2(FRAME_LINES);
  localparam int ADDR_W = PIX_CW + LIDX_W;
  localparam logic [PIX_CW-1:0] PIX_LAST  = PIX_CW'(LINE_PIX - 1);
  localparam logic [LIDX_W:0]   LINE_FULL = (LIDX_W+1)'(FRAME_LINES);

  logic [LIDX_W:0]    line_q;
  logic [PIX_CW-1:0]  pix_q;
  logic               wr_valid_q;
  logic [ADDR_W-1:0]  wr_addr_q;
  logic [PIX_W-1:0]   wr_data_q;
  logic               ovf_q;
  logic               take;
  logic               full;
  logic               pix_last;

  // The output register may refill in the same cycle it drains
  assign in_ready = !frame_start && (!wr_valid_q || wr_ready);
  assign take     = in_valid && in_ready;
  assign full     = (line_q == LINE_FULL);
  assign pix_last = (pix_q == PIX_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      line_q     <= '0;
      pix_q      <= '0;
      wr_valid_q <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      ovf_q      <= 1'b0;
    end else begin
      if (wr_valid_q && wr_ready) begin
        wr_valid_q <= 1'b0;
      end
      if (frame_start) begin
        line_q <= '0;
        pix_q  <= '0;
      end else if (take) begin
        if (full) begin
          ovf_q <= 1'b1;
        end else begin
          wr_valid_q <= 1'b1;
          wr_addr_q  <= {line_q[LIDX_W-1:0], pix_q};
          wr_data_q  <= in_data;
          if (pix_last) begin
            pix_q  <= '0;
            line_q <= line_q + 1'b1;
          end else begin
            pix_q <= pix_q + 1'b1;
          end
        end
      end
    end
  end

  assign wr_valid = wr_valid_q;
  assign wr_addr  = wr_addr_q;
  assign wr_data  = wr_data_q;
  assign overflow = ovf_q;

endmodule

// File: rtl/lws_track.sv
module lws_track #(
  parameter int LINE_PIX    = 512,
  parameter int FRAME_LINES = 1024
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     frame_start,
  input  logic                                     wr_fire,
  input  logic [$clog2(LINE_PIX*FRAME_LINES)-1:0]  wr_addr,
  output logic                                     line_irq,
  output logic [$clog2(FRAME_LINES)-1:0]           line_irq_idx,
  output logic [$clog2(FRAME_LINES):0]             lines_done,
  output logic                                     half_go
);
  localparam int PIX_CW = $clog2(LINE_PIX);
  localparam int LIDX_W = $clog2(FRAME_LINES);
  localparam int ADDR_W = PIX_CW + LIDX_W;
  localparam logic [PIX_CW-1:0] PIX_LAST = PIX_CW'(LINE_PIX - 1);
  localparam logic [LIDX_W:0]   HALF_M1  = (LIDX_W+1)'(FRAME_LINES/2 - 1);

  logic               fire_last;
  logic               irq_q;
  logic [LIDX_W-1:0]  idx_q;
  logic [LIDX_W:0]    done_q;
  logic               go_q;

  // A line is finished only when memory takes its final word
  assign fire_last = wr_fire && (wr_addr[PIX_CW-1:0] == PIX_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_q  <= 1'b0;
      idx_q  <= '0;
      done_q <= '0;
      go_q   <= 1'b0;
    end else begin
      irq_q <= fire_last;
      go_q  <= 1'b0;
      if (fire_last) begin
        idx_q <= wr_addr[ADDR_W-1:PIX_CW];
      end
      if (frame_start) begin
        done_q <= '0;
      end else if (fire_last) begin
        done_q <= done_q + 1'b1;
        if (done_q == HALF_M1) begin
          go_q <= 1'b1;
        end
      end
    end
  end

  assign line_irq     = irq_q;
  assign line_irq_idx = idx_q;
  assign lines_done   = done_q;
  assign half_go      = go_q;

endmodule

// File: rtl/lws_egress.sv
module lws_egress
  import lws_pkg::*;
#(
  parameter int PIX_W       = 24,
  parameter int LINE_PIX    = 512,
  parameter int FRAME_LINES = 1024
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     frame_start,
  input  logic                                     half_go,
  input  logic [$clog2(FRAME_LINES):0]             lines_done,
  output logic                                     rd_valid,
  output logic [$clog2(LINE_PIX*FRAME_LINES)-1:0]  rd_addr,
  input  logic                                     rd_ready,
  input  logic                                     rd_rsp_valid,
  input  logic [PIX_W-1:0]                         rd_rsp_data,
  output logic                                     out_valid,
  output logic [PIX_W-1:0]                         out_data
);
  localparam int PIX_CW = $clog2(LINE_PIX);
  localparam int LIDX_W = $clog2(FRAME_LINES);
  localparam int ADDR_W = PIX_CW + LIDX_W;
  localparam logic [PIX_CW-1:0] PIX_LAST  = PIX_CW'(LINE_PIX - 1);
  localparam logic [LIDX_W:0]   LINE_LAST = (LIDX_W+1)'(FRAME_LINES - 1);

  eg_state_t          st_q;
  logic [LIDX_W:0]    line_q;
  logic [PIX_CW-1:0]  pix_q;
  logic               rd_valid_q;
  logic [ADDR_W-1:0]  rd_addr_q;
  logic               out_valid_q;
  logic [PIX_W-1:0]   out_data_q;
  logic               avail;
  logic               adv;

  // Only lines already reported complete may be read
  assign avail = (st_q == EG_RUN) && (line_q < lines_done);
  assign adv   = !rd_valid_q || rd_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= EG_IDLE;
      line_q      <= '0;
      pix_q       <= '0;
      rd_valid_q  <= 1'b0;
      rd_addr_q   <= '0;
      out_valid_q <= 1'b0;
      out_data_q  <= '0;
    end else begin
      out_valid_q <= rd_rsp_valid;
      out_data_q  <= rd_rsp_data;
      if (frame_start) begin
        st_q       <= EG_IDLE;
        line_q     <= '0;
        pix_q      <= '0;
        rd_valid_q <= 1'b0;
      end else begin
        if (st_q == EG_IDLE && half_go) begin
          st_q <= EG_RUN;
        end
        if (adv) begin
          rd_valid_q <= avail;
          if (avail) begin
            rd_addr_q <= {line_q[LIDX_W-1:0], pix_q};
            if (pix_q == PIX_LAST) begin
              pix_q  <= '0;
              line_q <= line_q + 1'b1;
              if (line_q == LINE_LAST) begin
                st_q <= EG_DONE;
              end
            end else begin
              pix_q <= pix_q + 1'b1;
            end
          end
        end
      end
    end
  end

  assign rd_valid  = rd_valid_q;
  assign rd_addr   = rd_addr_q;
  assign out_valid = out_valid_q;
  assign out_data  = out_data_q;

endmodule

// File: rtl/line_wr_seq.sv
module line_wr_seq #(
  parameter int PIX_W       = 24,
  parameter int LINE_PIX    = 512,
  parameter int FRAME_LINES = 1024
) (
  input  logic                                     clk,
  input  logic                                     rst,
  input  logic                                     frame_start,
  input  logic                                     in_valid,
  input  logic [PIX_W-1:0]                         in_data,
  output logic                                     in_ready,
  output logic                                     wr_valid,
  output logic [$clog2(LINE_PIX*FRAME_LINES)-1:0]  wr_addr,
  output logic [PIX_W-1:0]                         wr_data,
  input  logic                                     wr_ready,
  output logic                                     rd_valid,
  output logic [$clog2(LINE_PIX*FRAME_LINES)-1:0]  rd_addr,
  input  logic                                     rd_ready,
  input  logic                                     rd_rsp_valid,
  input  logic [PIX_W-1:0]                         rd_rsp_data,
  output logic                                     out_valid,
  output logic [PIX_W-1:0]                         out_data,
  output logic                                     line_irq,
  output logic [$clog2(FRAME_LINES)-1:0]           line_irq_idx,
  output logic                                     overflow
);
  localparam int LIDX_W = $clog2(FRAME_LINES);

  logic              wr_fire;
  logic [LIDX_W:0]   lines_done;
  logic              half_go;

  assign wr_fire = wr_valid && wr_ready;

  lws_ingress #(
    .PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES)
  ) u_ingress (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_ready(wr_ready), .overflow(overflow)
  );

  lws_track #(
    .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES)
  ) u_track (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .wr_fire(wr_fire), .wr_addr(wr_addr),
    .line_irq(line_irq), .line_irq_idx(line_irq_idx),
    .lines_done(lines_done), .half_go(half_go)
  );

  lws_egress #(
    .PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES)
  ) u_egress (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .half_go(half_go), .lines_done(lines_done),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .out_valid(out_valid), .out_data(out_data)
  );

endmodule

// File: rtl/lws_checker.sv
module lws_checker #(
  parameter int PIX_W       = 24,
  parameter int LINE_PIX    = 512,
  parameter int FRAME_LINES = 1024
) (
  input logic                                     clk,
  input logic                                     rst,
  input logic                                     frame_start,
  input logic                                     in_valid,
  input logic                                     in_ready,
  input logic                                     wr_valid,
  input logic [$clog2(LINE_PIX*FRAME_LINES)-1:0]  wr_addr,
  input logic [PIX_W-1:0]                         wr_data,
  input logic                                     wr_ready,
  input logic                                     rd_valid,
  input logic [$clog2(LINE_PIX*FRAME_LINES)-1:0]  rd_addr,
  input logic                                     rd_ready,
  input logic                                     line_irq,
  input logic                                     overflow
);
  localparam int PIX_CW = $clog2(LINE_PIX);
  localparam logic [PIX_CW-1:0] PIX_LAST = PIX_CW'(LINE_PIX - 1);

  a_r3_wr_hold: assert property (@(posedge clk) disable iff (rst)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  a_r4_irq_single: assert property (@(posedge clk) disable iff (rst)
    line_irq |=> !line_irq);

  a_r4_irq_after_last: assert property (@(posedge clk) disable iff (rst)
    line_irq |-> $past(wr_valid && wr_ready && (wr_addr[PIX_CW-1:0] == PIX_LAST)));

  a_r7_rd_hold: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && !rd_ready && !frame_start) |=> (rd_valid && $stable(rd_addr)));

  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);

  a_r10_ovf_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(in_valid && in_ready));

endmodule

bind line_wr_seq lws_checker #(
  .PIX_W(PIX_W), .LINE_PIX(LINE_PIX), .FRAME_LINES(FRAME_LINES)
) u_chk (.*);

// File: tb/line_wr_seq_bench.sv
module line_wr_seq_bench;
  localparam int PW   = 24;
  localparam int LP   = 8;
  localparam int FL   = 8;
  localparam int HALF = FL / 2;
  localparam int NPIX = LP * FL;
  localparam int AW   = 6;
  localparam int PCW  = 3;
  localparam int LW   = 3;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, frame_start, in_valid, in_ready;
  logic [PW-1:0] in_data;
  logic wr_valid, wr_ready;
  logic [AW-1:0] wr_addr;
  logic [PW-1:0] wr_data;
  logic rd_valid, rd_ready;
  logic [AW-1:0] rd_addr;
  logic rd_rsp_valid;
  logic [PW-1:0] rd_rsp_data;
  logic out_valid;
  logic [PW-1:0] out_data;
  logic line_irq;
  logic [LW-1:0] line_irq_idx;
  logic overflow;

  line_wr_seq #(.PIX_W(PW), .LINE_PIX(LP), .FRAME_LINES(FL)) u_line_wr_seq (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_ready(wr_ready),
    .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .out_valid(out_valid), .out_data(out_data),
    .line_irq(line_irq), .line_irq_idx(line_irq_idx), .overflow(overflow)
  );

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  logic [AW+PW-1:0] exp_wr[$];
  logic [PW-1:0]    exp_out[$];
  logic [PW-1:0]    mem [0:NPIX-1];

  int  cyc = 0;
  int  irq_seen = 0;
  int  rd_next = 0;
  int  wr_count = 0;
  int  nb_seen = 0;
  bit  irq_due = 1'b0;
  int  irq_due_idx = 0;
  bit  rsp_pend = 1'b0;
  logic [AW-1:0] rsp_addr;
  bit  prev_stall = 1'b0;
  logic [AW-1:0] prev_addr;
  logic [PW-1:0] prev_data;
  bit  mon_on = 1'b0;
  bit  first_check = 1'b0;

  function automatic logic [PW-1:0] pixval(input int f, input int a);
    return PW'(a * 37 + f * 4096 + 24'h300000);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  // Memory side: stall patterns and one-cycle read latency
  always @(negedge clk) begin
    cyc++;
    wr_ready     = (cyc % 4) != 3;
    rd_ready     = (cyc % 5) != 2;
    rd_rsp_valid = rsp_pend;
    rd_rsp_data  = rsp_pend ? mem[rsp_addr] : '0;
    rsp_pend     = 1'b0;
  end

  // Monitor: sampled mid-cycle, away from both edges
  always begin
    @(negedge clk);
    #2;
    if (mon_on) begin
      if (irq_due) begin
        chk(line_irq === 1'b1 && int'(line_irq_idx) == irq_due_idx, "R4",
            "irq index", line_irq ? int'(line_irq_idx) : -1, irq_due_idx);
      end else if (line_irq) begin
        chk(1'b0, "R4", "unexpected irq", 1, 0);
      end
      if (line_irq) irq_seen++;
      irq_due = 1'b0;

      if (prev_stall) begin
        chk(wr_valid && wr_addr == prev_addr && wr_data == prev_data, "R3",
            "held write addr", wr_addr, prev_addr);
      end
      prev_stall = wr_valid && !wr_ready;
      prev_addr  = wr_addr;
      prev_data  = wr_data;

      if (wr_valid && wr_ready) begin
        if (exp_wr.size() == 0) begin
          chk(1'b0, "R2", "write with none expected", wr_addr, -1);
        end else begin
          logic [AW+PW-1:0] e;
          e = exp_wr.pop_front();
          chk(wr_addr == e[AW+PW-1:PW], "R2", "write addr", wr_addr, e[AW+PW-1:PW]);
          chk(wr_data == e[PW-1:0], "R2", "write data", wr_data, e[PW-1:0]);
        end
        if (first_check) begin
          chk(wr_addr == '0, "R9", "first addr after frame_start", wr_addr, 0);
          first_check = 1'b0;
        end
        mem[wr_addr] = wr_data;
        wr_count++;
        if (int'(wr_addr[PCW-1:0]) == LP - 1) begin
          irq_due = 1'b1;
          irq_due_idx = int'(wr_addr >> PCW);
        end
      end

      if (out_valid) begin
        if (exp_out.size() == 0) begin
          chk(1'b0, "R8", "output with none expected", out_data, -1);
        end else begin
          logic [PW-1:0] eo;
          eo = exp_out.pop_front();
          chk(out_data == eo, "R8", "egress data", out_data, eo);
        end
      end

      if (rd_valid && rd_ready) begin
        chk(irq_seen >= HALF, "R5", "lines done at first reads", irq_seen, HALF);
        chk(int'(rd_addr) == rd_next, "R6", "read addr order", rd_addr, rd_next);
        chk(int'(rd_addr >> PCW) < irq_seen, "R6", "read of unfinished line",
            rd_addr >> PCW, irq_seen);
        if (exp_out.size() > 0) nb_seen++;
        exp_out.push_back(pixval(1, int'(rd_addr)));
        rsp_pend = 1'b1;
        rsp_addr = rd_addr;
        rd_next++;
      end
    end
  end

  task automatic send_pixel(input logic [PW-1:0] d, input bit expect_wr, input int addr);
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = d;
    if (expect_wr) exp_wr.push_back({AW'(addr), d});
    forever begin
      #2;
      if (in_ready) begin
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
  endtask

  task automatic send_frame(input int f, input int nlines);
    for (int a = 0; a < nlines * LP; a++) begin
      if (a % 5 == 4) @(negedge clk);
      send_pixel(pixval(f, a), 1'b1, a);
    end
  endtask

  task automatic pulse_frame_start();
    @(negedge clk);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(8 * 100000);
    fails++;
    $display("FAIL R1 watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    rst = 1'b1; frame_start = 1'b0; in_valid = 1'b0; in_data = '0;
    wr_ready = 1'b0; rd_ready = 1'b0; rd_rsp_valid = 1'b0; rd_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    chk(wr_valid == 0, "R1", "wr_valid", wr_valid, 0);
    chk(rd_valid == 0, "R1", "rd_valid", rd_valid, 0);
    chk(out_valid == 0, "R1", "out_valid", out_valid, 0);
    chk(line_irq == 0, "R1", "line_irq", line_irq, 0);
    chk(overflow == 0, "R1", "overflow", overflow, 0);
    mon_on = 1'b1;

    // Frame 1: full frame, egress starts at half
    pulse_frame_start();
    send_frame(1, FL);
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      if (rd_next == NPIX && exp_out.size() == 0 && exp_wr.size() == 0) break;
    end
    #2;
    chk(exp_wr.size() == 0, "R2", "pending writes", exp_wr.size(), 0);
    chk(wr_count == NPIX, "R3", "write count", wr_count, NPIX);
    chk(irq_seen == FL, "R4", "irq count", irq_seen, FL);
    chk(rd_next == NPIX, "R6", "reads issued", rd_next, NPIX);
    chk(exp_out.size() == 0, "R8", "pending egress", exp_out.size(), 0);
    chk(nb_seen > 0, "R7", "reads overlapping responses", nb_seen, 1);
    chk(overflow == 0, "R10", "overflow before excess", overflow, 0);

    // Excess pixels past the frame end
    send_pixel(24'h0BAD01, 1'b0, 0);
    send_pixel(24'h0BAD02, 1'b0, 0);
    repeat (4) @(negedge clk);
    #2;
    chk(wr_count == NPIX, "R10", "no write for dropped pixels", wr_count, NPIX);
    chk(wr_valid == 0, "R10", "wr_valid idle", wr_valid, 0);
    chk(overflow == 1, "R10", "overflow set", overflow, 1);

    // Frame 2: restart, fewer than half the lines
    first_check = 1'b1;
    pulse_frame_start();
    send_frame(2, HALF - 1);
    repeat (20) @(negedge clk);
    #2;
    chk(irq_seen == FL + HALF - 1, "R9", "irq count frame 2", irq_seen, FL + HALF - 1);
    chk(rd_next == NPIX, "R9", "no reads after restart", rd_next, NPIX);
    chk(rd_valid == 0, "R5", "rd_valid below half", rd_valid, 0);
    chk(overflow == 1, "R10", "overflow sticky", overflow, 1);
    chk(exp_wr.size() == 0, "R2", "pending writes frame 2", exp_wr.size(), 0);
    summary();
  end

endmodule